// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

This block is a performance-monitoring unit with a bank of 64-bit event counters. Each counter watches one line of a wide vector of single-cycle event strobes. The line is chosen by an 8-bit code that software programs. A counter advances by one on every cycle in which its chosen strobe is high, but only while both the unit-wide enable and the counter's own enable are set.

Software reaches the unit through a plain 32-bit register port. Reads are combinational from the address. A write is a one-cycle strobe and takes effect at the next rising clock edge. Each counter is mapped as a pair of 32-bit words, so it can be read or preloaded. When a counter wraps from all ones to zero, its overflow status bit is set, and an interrupt line reports any status bit that is not masked. Depending on a build parameter, status is cleared through a separate clear word or by writing ones to the status word itself. Three filter configuration words and a read-only version word are also provided.

Top module: `evcnt_unit`

## Requirements
- R1: After reset the enable, counter-enable, select, filter, status and counter words read zero, the mask word reads all ones (0xFF for eight counters), and `irq` is low.
- R2: Counter n increments by one on a cycle where its selected strobe is high only if bit 0 of word 0x1C00 (unit enable) and bit n of word 0x1C04 (counter enable) are both set; otherwise it holds.
- R3: The select code of counter n is the byte at bits 8*(n mod 4) of word 0x1C80 + 4*(n div 4); counter n counts `ev_strobe[code]` and ignores every other strobe line.
- R4: Counter n reads and writes as a low word at 0x1D00 + 8n and a high word at 0x1D04 + 8n; a write to either half takes precedence over an increment in the same cycle and leaves the other half unchanged.
- R5: An increment from all ones wraps the counter to zero and sets bit n of the status word.
- R6: `irq` is high exactly when some status bit is set whose mask bit is 0; a mask bit of 1 suppresses that counter.
- R7: Writing 1 to a status bit clears only that bit. With LAYOUT=0 the mask is at 0x1C70, the status at 0x1C78 (writes there are ignored) and the clear word at 0x1C7C. With LAYOUT=1 the status is at 0x1C70 and is cleared by writes to it, and the mask is at 0x1C74.
- R8: Words 0x1C14 and 0x1C18 store bits 22:0 (command in bits 10:0, enable in bit 11, mask in bits 22:12), and word 0x1C08 stores only bit 4; all other bits read zero.
- R9: Unmapped offsets, and addresses with a nonzero bits 1:0, read zero and ignore writes.
- R10: Word 0x1CF0 reads the VERSION parameter, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ev_strobe | input | 256 | Single-cycle event strobes |
| irq | output | 1 | Unmasked overflow interrupt |

## Verification
Read data is combinational, so a read is due in the same cycle once the address settles. A write, a counting strobe or a wrap shows in the read data, the status word and `irq` right after the next rising edge. The bench drives every input at a falling edge, holds it across exactly one rising edge, and samples at the following falling edge. This always lands one register stage after the stimulus. The cycle where a counter write and a strobe coincide is driven as one combined stimulus, so the check observes the precedence rule directly.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam logic [15:0] A_CTRL  = 16'h1c00;
  localparam logic [15:0] A_CNTEN = 16'h1c04;
  localparam logic [15:0] A_TTAG  = 16'h1c08;
  localparam logic [15:0] A_FLT0  = 16'h1c14;
  localparam logic [15:0] A_FLT1  = 16'h1c18;
  localparam logic [15:0] A_EVSEL = 16'h1c80;
  localparam logic [15:0] A_VER   = 16'h1cf0;
  localparam logic [15:0] A_CNT   = 16'h1d00;
  localparam int          FLT_W   = 23;
  localparam int          TTAG_BIT = 4;
endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT   = 8,
  parameter int SEL_WORDS = 2,
  parameter int LAYOUT    = 0,
  parameter int IDX_W     = 3,
  parameter int SIDX_W    = 1
) (
  input  logic [15:0]       addr,
  output logic              hit_ctrl,
  output logic              hit_cnten,
  output logic              hit_ttag,
  output logic              hit_flt0,
  output logic              hit_flt1,
  output logic              hit_mask,
  output logic              hit_stat,
  output logic              hit_clr,
  output logic              hit_ver,
  output logic              hit_sel,
  output logic [SIDX_W-1:0] sel_idx,
  output logic              hit_cnt,
  output logic [IDX_W-1:0]  cnt_idx,
  output logic              cnt_hi,
  output logic              any_hit
);
  localparam logic [15:0] A_MASK = (LAYOUT != 0) ? 16'h1c74 : 16'h1c70;
  localparam logic [15:0] A_STAT = (LAYOUT != 0) ? 16'h1c70 : 16'h1c78;
  localparam logic [15:0] A_CLR  = 16'h1c7c;
  localparam logic [15:0] CNT_END = A_CNT + 16'(NUM_CNT * 8);
  localparam logic [15:0] SEL_END = A_EVSEL + 16'(SEL_WORDS * 4);

  logic aligned;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    hit_ctrl  = aligned && (addr == A_CTRL);
    hit_cnten = aligned && (addr == A_CNTEN);
    hit_ttag  = aligned && (addr == A_TTAG);
    hit_flt0  = aligned && (addr == A_FLT0);
    hit_flt1  = aligned && (addr == A_FLT1);
    hit_mask  = aligned && (addr == A_MASK);
    hit_stat  = aligned && (addr == A_STAT);
    hit_clr   = (LAYOUT != 0) ? hit_stat : (aligned && (addr == A_CLR));
    hit_ver   = aligned && (addr == A_VER);
    hit_sel   = aligned && (addr >= A_EVSEL) && (addr < SEL_END);
    sel_idx   = SIDX_W'((addr - A_EVSEL) >> 2);
    hit_cnt   = aligned && (addr >= A_CNT) && (addr < CNT_END);
    cnt_idx   = IDX_W'((addr - A_CNT) >> 3);
    cnt_hi    = addr[2];
    any_hit   = hit_ctrl | hit_cnten | hit_ttag | hit_flt0 | hit_flt1 |
                hit_mask | hit_stat | hit_clr | hit_ver | hit_sel | hit_cnt;
  end
endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [31:0]  wdata,
  output logic [W-1:0] value,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) value[31:0]  <= wdata;
      if (wr_hi) value[W-1:32] <= wdata[W-33:0];
    end else if (inc) begin
      value <= value + 1'b1;
    end
  end

  assign wrap = inc && !wr_lo && !wr_hi && (&value);
endmodule

// File: rtl/evcnt_irq.sv
module evcnt_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap,
  input  logic         mask_wr,
  input  logic         clr_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] status_q,
  output logic         irq
);
  logic [N-1:0] clr_bits;

  always_comb clr_bits = clr_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      status_q <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      status_q <= (status_q & ~clr_bits) | wrap;
    end
  end

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 64,
  parameter int          CODE_W  = 8,
  parameter int          NUM_EV  = 256,
  parameter int          LAYOUT  = 0,
  parameter logic [31:0] VERSION = 32'h0000_0301
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [15:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_EV-1:0] ev_strobe,
  output logic              irq
);
  localparam int PER_WORD  = 32 / CODE_W;
  localparam int SEL_WORDS = (NUM_CNT + PER_WORD - 1) / PER_WORD;
  localparam int IDX_W     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int SIDX_W    = (SEL_WORDS > 1) ? $clog2(SEL_WORDS) : 1;

  logic              hit_ctrl, hit_cnten, hit_ttag, hit_flt0, hit_flt1;
  logic              hit_mask, hit_stat, hit_clr, hit_ver, hit_sel, hit_cnt;
  logic              cnt_hi, any_hit, wr;
  logic [SIDX_W-1:0] sel_idx;
  logic [IDX_W-1:0]  cnt_idx;

  logic               ctrl_en, ttag_en;
  logic [NUM_CNT-1:0] cnten_q;
  logic [FLT_W-1:0]   flt0_q, flt1_q;
  logic [31:0]        selw_q [SEL_WORDS];

  logic [NUM_CNT-1:0] inc_vec, wrap_vec, mask_q, status_q;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  evcnt_decode #(
    .NUM_CNT(NUM_CNT), .SEL_WORDS(SEL_WORDS), .LAYOUT(LAYOUT),
    .IDX_W(IDX_W), .SIDX_W(SIDX_W)
  ) u_dec (
    .addr(bus_addr), .hit_ctrl(hit_ctrl), .hit_cnten(hit_cnten),
    .hit_ttag(hit_ttag), .hit_flt0(hit_flt0), .hit_flt1(hit_flt1),
    .hit_mask(hit_mask), .hit_stat(hit_stat), .hit_clr(hit_clr),
    .hit_ver(hit_ver), .hit_sel(hit_sel), .sel_idx(sel_idx),
    .hit_cnt(hit_cnt), .cnt_idx(cnt_idx), .cnt_hi(cnt_hi), .any_hit(any_hit)
  );

  assign wr = bus_sel && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      ttag_en <= 1'b0;
      cnten_q <= '0;
      flt0_q  <= '0;
      flt1_q  <= '0;
      for (int i = 0; i < SEL_WORDS; i++) selw_q[i] <= '0;
    end else if (wr) begin
      if (hit_ctrl)  ctrl_en <= bus_wdata[0];
      if (hit_ttag)  ttag_en <= bus_wdata[TTAG_BIT];
      if (hit_cnten) cnten_q <= bus_wdata[NUM_CNT-1:0];
      if (hit_flt0)  flt0_q  <= bus_wdata[FLT_W-1:0];
      if (hit_flt1)  flt1_q  <= bus_wdata[FLT_W-1:0];
      if (hit_sel)   selw_q[sel_idx] <= bus_wdata;
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic [CODE_W-1:0] code;
    logic              wlo, whi;
    assign code = selw_q[n / PER_WORD][CODE_W * (n % PER_WORD) +: CODE_W];
    assign inc_vec[n] = ctrl_en && cnten_q[n] && ev_strobe[code];
    assign wlo = wr && hit_cnt && (cnt_idx == IDX_W'(n)) && !cnt_hi;
    assign whi = wr && hit_cnt && (cnt_idx == IDX_W'(n)) && cnt_hi;

    evcnt_counter #(.W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[n]), .wr_lo(wlo), .wr_hi(whi),
      .wdata(bus_wdata), .value(cnt_val[n]), .wrap(wrap_vec[n])
    );
  end

  evcnt_irq #(.N(NUM_CNT)) u_irq (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_vec),
    .mask_wr(wr && hit_mask), .clr_wr(wr && hit_clr),
    .wdata(bus_wdata[NUM_CNT-1:0]), .mask_q(mask_q), .status_q(status_q),
    .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (hit_ctrl)       bus_rdata = {31'b0, ctrl_en};
      else if (hit_cnten) bus_rdata = 32'(cnten_q);
      else if (hit_ttag)  bus_rdata = 32'(ttag_en) << TTAG_BIT;
      else if (hit_flt0)  bus_rdata = 32'(flt0_q);
      else if (hit_flt1)  bus_rdata = 32'(flt1_q);
      else if (hit_mask)  bus_rdata = 32'(mask_q);
      else if (hit_stat)  bus_rdata = 32'(status_q);
      else if (hit_ver)   bus_rdata = VERSION;
      else if (hit_sel)   bus_rdata = selw_q[sel_idx];
      else if (hit_cnt)   bus_rdata = cnt_hi ? 32'(cnt_val[cnt_idx] >> 32)
                                             : cnt_val[cnt_idx][31:0];
    end
  end
endmodule

// File: rtl/evcnt_unit_chk.sv
module evcnt_unit_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         any_hit,
  input logic [31:0]  bus_rdata,
  input logic         ctrl_en,
  input logic [N-1:0] wrap_vec,
  input logic [N-1:0] status_q,
  input logic [N-1:0] mask_q,
  input logic         irq
);
  // R2
  no_wrap_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (wrap_vec == '0));

  // R5
  wrap_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((status_q & $past(wrap_vec)) == $past(wrap_vec)));

  // R7
  status_rises_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(wrap_vec)) == '0));

  // R6
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  // R6
  unmasked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q != '0) && (mask_q == '0)) |-> irq);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !any_hit) |-> (bus_rdata == 32'h0));
endmodule

bind evcnt_unit evcnt_unit_chk #(.N(NUM_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .any_hit(any_hit),
  .bus_rdata(bus_rdata), .ctrl_en(ctrl_en), .wrap_vec(wrap_vec),
  .status_q(status_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/evcnt_unit_tb.sv
module evcnt_unit_tb;
  localparam logic [31:0] VER = 32'h0000_0301;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [255:0] ev_strobe = '0;
  logic        irq0, irq1;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  evcnt_unit #(.LAYOUT(0), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .ev_strobe(ev_strobe), .irq(irq0));

  evcnt_unit #(.LAYOUT(1), .VERSION(VER)) u_dut_l1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .ev_strobe(ev_strobe), .irq(irq1));

  // write, readback address, expected readback
  localparam int NV = 11;
  localparam logic [79:0] VEC [NV] = '{
    {16'h1c14, 32'hffff_ffff, 32'h007f_ffff},
    {16'h1c18, 32'h1234_5678, 32'h0034_5678},
    {16'h1c08, 32'hffff_ffff, 32'h0000_0010},
    {16'h1c08, 32'hffff_ffef, 32'h0000_0000},
    {16'h1c80, 32'h0403_0201, 32'h0403_0201},
    {16'h1c0c, 32'hffff_ffff, 32'h0000_0000},
    {16'h1cf0, 32'hffff_ffff, VER},
    {16'h1c02, 32'hffff_ffff, 32'h0000_0000},
    {16'h1d40, 32'hffff_ffff, 32'h0000_0000},
    {16'h1c04, 32'h0000_00ff, 32'h0000_00ff},
    {16'h1c04, 32'h0000_0000, 32'h0000_0000}
  };
  localparam string VTAG [NV] = '{"R8", "R8", "R8", "R8", "R3", "R9",
                                  "R10", "R9", "R9", "R2", "R2"};

  task automatic check(input string tag, input logic [31:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input bit alt, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = alt ? rdata1 : rdata0;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    ev_strobe[idx] = 1'b1;
    @(negedge clk);
    ev_strobe = '0;
  endtask

  task automatic finish_run;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(16'h1c00, 0, v); check("R1 ctrl", v, 32'h0);
    rd(16'h1c70, 0, v); check("R1 mask", v, 32'hff);
    rd(16'h1c78, 0, v); check("R1 status", v, 32'h0);
    rd(16'h1d00, 0, v); check("R1 counter0", v, 32'h0);
    rd(16'h1c84, 0, v); check("R1 select1", v, 32'h0);
    check("R1 irq", 32'(irq0), 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:64], VEC[i][63:32]);
      rd(VEC[i][79:64], 0, v);
      check(VTAG[i], v, VEC[i][31:0]);
    end

    // R9 misaligned write left the enable word alone
    rd(16'h1c00, 0, v); check("R9 ctrl untouched", v, 32'h0);

    // R2 gating
    wr(16'h1c04, 32'h01);
    pulse(1);
    rd(16'h1d00, 0, v); check("R2 unit disabled", v, 32'h0);
    wr(16'h1c00, 32'h1);
    pulse(1); pulse(1); pulse(1);
    rd(16'h1d00, 0, v); check("R2 counts three", v, 32'h3);
    pulse(2);
    rd(16'h1d08, 0, v); check("R2 counter disabled", v, 32'h0);

    // R3 select code 0xAB for counter 5
    wr(16'h1c84, 32'h0000_ab00);
    wr(16'h1c04, 32'h21);
    pulse(8'haa);
    rd(16'h1d28, 0, v); check("R3 other line ignored", v, 32'h0);
    pulse(8'hab);
    rd(16'h1d28, 0, v); check("R3 selected line", v, 32'h1);
    rd(16'h1d00, 0, v); check("R3 counter0 unchanged", v, 32'h3);

    // R4 preload and precedence on counter 2 (code 3)
    wr(16'h1d14, 32'hffff_ffff);
    wr(16'h1d10, 32'hffff_fffe);
    rd(16'h1d14, 0, v); check("R4 high word", v, 32'hffff_ffff);
    wr(16'h1c04, 32'h25);
    pulse(3);
    rd(16'h1d10, 0, v); check("R4 increment low", v, 32'hffff_ffff);
    @(negedge clk);
    ev_strobe[3] = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 16'h1d10; bus_wdata = 32'h10;
    @(negedge clk);
    ev_strobe = '0; bus_sel = 1'b0; bus_we = 1'b0;
    rd(16'h1d10, 0, v); check("R4 write wins", v, 32'h10);
    rd(16'h1d14, 0, v); check("R4 other half kept", v, 32'hffff_ffff);

    // R5 wrap
    wr(16'h1d10, 32'hffff_ffff);
    pulse(3);
    rd(16'h1d10, 0, v); check("R5 wrap low", v, 32'h0);
    rd(16'h1d14, 0, v); check("R5 wrap high", v, 32'h0);
    rd(16'h1c78, 0, v); check("R5 status bit2", v, 32'h4);
    check("R6 masked irq", 32'(irq0), 32'h0);
    wr(16'h1c70, 32'hfb);
    check("R6 unmasked irq", 32'(irq0), 32'h1);

    // R7 clearing, layout 0
    wr(16'h1c78, 32'h4);
    rd(16'h1c78, 0, v); check("R7 status word read-only", v, 32'h4);
    wr(16'h1c7c, 32'h1);
    rd(16'h1c78, 0, v); check("R7 other bit clear", v, 32'h4);
    wr(16'h1c7c, 32'h4);
    rd(16'h1c78, 0, v); check("R7 cleared", v, 32'h0);
    check("R7 irq dropped", 32'(irq0), 32'h0);

    // R7 layout 1
    rd(16'h1c74, 1, v); check("R7 alt mask", v, 32'hff);
    rd(16'h1c70, 1, v); check("R7 alt status", v, 32'h4);
    check("R6 alt masked irq", 32'(irq1), 32'h0);
    wr(16'h1c70, 32'h4);
    rd(16'h1c70, 1, v); check("R7 alt write clears", v, 32'h0);

    finish_run();
  end
endmodule